// File: doc/BRIEF.md
# Hardware Priority Task Scheduler

This block picks the task that owns a processor core whose tasks each keep their own banked pipeline context, so a switch costs no save or restore cycles. Interrupt sources are not a separate level. Each one is an ordinary task slot in a single fixed-priority space, and its slot position sets its rank among the other tasks.

A slot becomes pending from one of three sources. A timer-driven slot is set by its own comparator against a shared free-running system timer. The other slots are set by the rising edge of an external line, or by a software activation naming the slot. A mask register hides pending slots from selection. An in-service register holds the slot that is running now. When the running task raises the done input, its pending bit is cleared.

The resolver works on the pending state for the next cycle. A request that arrives on a clock edge therefore owns the core from that same edge. Every timer-driven slot also has a watchdog, which expects exactly one progress report from the task in each period.

Top module: `hw_task_sched`

## Requirements
- R1: Slot 0 has the highest priority and slot NUM_TASKS-1 the lowest. The block outputs the lowest-numbered slot that is pending and unmasked. That index is registered, and it changes on the same clock edge that registers the request.
- R2: On a slot that is not timer-driven, a rising edge of that slot's external line sets the pending bit. A line that stays high does not set the bit again after it has been cleared.
- R3: While the software activation input is high, the slot named by the activation index becomes pending. Timer-driven slots ignore both external lines and software activation.
- R4: A write to address NUM_TASKS loads the mask from the low data bits, where bit i masks slot i. A masked slot is never selected. Its pending bit is kept, and the slot can be selected as soon as the mask bit clears.
- R5: A higher-priority request that arrives while a lower-priority task runs takes the core one clock edge after its input is seen, with no idle cycle between the two tasks.
- R6: While a task is running, the done input clears that task's pending bit. On the same edge the next pending slot is selected, or the core goes idle.
- R7: When no slot is pending and unmasked, the valid output is low and the index output is 0.
- R8: A write of period P to address i of a timer-driven slot arms its comparator. The slot becomes pending P edges after the write edge and again every P edges after that. P = 0 stops the activations.
- R9: The first activation of a timer-driven slot opens its watchdog window. At each later activation, the slot's error bit is set unless exactly one progress report arrived in the window just closed. A report counts only when the progress input is high while that slot is running.
- R10: A watchdog error bit stays set until a period write to that slot clears it. Slots that are not timer-driven never report an error.
- R11: Synchronous reset clears the pending, mask, in-service and error state, the stored periods and the system timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Address 0..NUM_TASKS-1 selects a period; address NUM_TASKS selects the mask |
| wr_data_i | input | DATA_W | Write data |
| irq_i | input | NUM_TASKS | External request lines, one per slot, sensed on the rising edge |
| sw_act_i | input | 1 | Software activation strobe |
| sw_act_idx_i | input | IDX_W | Slot named by the software activation |
| done_i | input | 1 | The running task has finished its work |
| beat_i | input | 1 | Progress report from the running task |
| run_idx_o | output | IDX_W | Index of the selected slot (0 when idle) |
| run_valid_o | output | 1 | A slot is selected |
| wdt_err_o | output | NUM_TASKS | Watchdog error, one bit per slot |

## Verification
A table of vectors loads a mask and then fires a burst of external edges. Each burst is chosen to separate one ordering rule: a single request, two requests far apart in priority, two adjacent requests where the higher one is masked, a fully masked burst, and bursts that hit timer-driven slots, which must be ignored. Directed sequences then cover the dynamic cases: preemption by a higher-priority edge while a lower task runs, release to the lower task on done, and a request held pending under a mask and released when the mask clears. A periodic slot is run with one good window and then one window with no report, which separates correct periodic activation from watchdog detection.

// File: rtl/sched_pkg.sv
package sched_pkg;
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sched_prio_pick.sv
module sched_prio_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |req_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/sched_tmr_cmp.sv
module sched_tmr_cmp #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] sys_time_i,
  input  logic          per_we_i,
  input  logic [TW-1:0] per_i,
  output logic          match_o
);
  logic [TW-1:0] period_q;
  logic [TW-1:0] cmp_q;

  assign match_o = (period_q != '0) && (sys_time_i == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      cmp_q    <= '0;
    end else if (per_we_i) begin
      period_q <= per_i;
      cmp_q    <= sys_time_i + per_i;
    end else if (match_o) begin
      cmp_q <= cmp_q + period_q;
    end
  end

  // R8
  reload_step_chk: assert property (@(posedge clk) disable iff (rst)
    (match_o && !per_we_i) |=> (cmp_q == $past(cmp_q + period_q)));
endmodule

// File: rtl/sched_wdog.sv
module sched_wdog (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  input  logic beat_i,
  output logic err_o
);
  logic       open_q;
  logic [1:0] cnt_q;
  logic       err_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else if (tick_i) begin
      if (open_q && cnt_q != 2'd1) err_q <= 1'b1;
      open_q <= 1'b1;
      cnt_q  <= {1'b0, beat_i};
    end else if (beat_i && cnt_q != 2'd2) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  assign err_o = err_q;

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> $past(clr_i));

  // R9
  miss_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && open_q && cnt_q == 2'd0 && !clr_i) |=> err_q);
endmodule

// File: rtl/hw_task_sched.sv
module hw_task_sched import sched_pkg::*; #(
  parameter int                   NUM_TASKS = 16,
  parameter int                   TIMER_W   = 16,
  parameter logic [NUM_TASKS-1:0] TIMER_EN  = 'h0F00,
  localparam int                  IDX_W     = idx_w(NUM_TASKS),
  localparam int                  ADDR_W    = idx_w(NUM_TASKS + 1),
  localparam int                  DATA_W    = imax(TIMER_W, NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [NUM_TASKS-1:0] irq_i,
  input  logic                 sw_act_i,
  input  logic [IDX_W-1:0]     sw_act_idx_i,
  input  logic                 done_i,
  input  logic                 beat_i,
  output logic [IDX_W-1:0]     run_idx_o,
  output logic                 run_valid_o,
  output logic [NUM_TASKS-1:0] wdt_err_o
);
  logic [TIMER_W-1:0]   sys_time_q;
  logic [NUM_TASKS-1:0] irq_prev_q;
  logic [NUM_TASKS-1:0] mask_q, mask_nxt;
  logic [NUM_TASKS-1:0] srr_q, srr_nxt;
  logic [NUM_TASKS-1:0] isr_q;
  logic [NUM_TASKS-1:0] tmr_match;
  logic [NUM_TASKS-1:0] sw_vec, ext_set;
  logic [IDX_W-1:0]     pick_idx;
  logic                 pick_any;
  logic                 mask_we;

  function automatic logic [NUM_TASKS-1:0] above_mask(input logic [IDX_W-1:0] idx);
    return (NUM_TASKS'(1) << idx) - NUM_TASKS'(1);
  endfunction

  assign mask_we  = wr_en_i && (wr_addr_i == ADDR_W'(NUM_TASKS));
  assign mask_nxt = mask_we ? wr_data_i[NUM_TASKS-1:0] : mask_q;
  assign sw_vec   = sw_act_i ? (NUM_TASKS'(1) << sw_act_idx_i) : '0;
  assign ext_set  = ((irq_i & ~irq_prev_q) | sw_vec) & ~TIMER_EN;
  assign srr_nxt  = (srr_q & ~(done_i ? isr_q : '0)) | tmr_match | ext_set;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TASKS; gi++) begin : g_slot
      if (TIMER_EN[gi]) begin : g_tmr
        logic per_we;
        assign per_we = wr_en_i && (wr_addr_i == ADDR_W'(gi));
        sched_tmr_cmp #(.TW(TIMER_W)) u_cmp (
          .clk        (clk),
          .rst        (rst),
          .sys_time_i (sys_time_q),
          .per_we_i   (per_we),
          .per_i      (wr_data_i[TIMER_W-1:0]),
          .match_o    (tmr_match[gi])
        );
        sched_wdog u_wdog (
          .clk    (clk),
          .rst    (rst),
          .clr_i  (per_we),
          .tick_i (tmr_match[gi]),
          .beat_i (beat_i && isr_q[gi]),
          .err_o  (wdt_err_o[gi])
        );
      end else begin : g_ext
        assign tmr_match[gi] = 1'b0;
        assign wdt_err_o[gi] = 1'b0;
      end
    end
  endgenerate

  sched_prio_pick #(.N(NUM_TASKS), .IW(IDX_W)) u_pick (
    .req_i (srr_nxt & ~mask_nxt),
    .idx_o (pick_idx),
    .any_o (pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_time_q  <= '0;
      irq_prev_q  <= '0;
      mask_q      <= '0;
      srr_q       <= '0;
      isr_q       <= '0;
      run_idx_o   <= '0;
      run_valid_o <= 1'b0;
    end else begin
      sys_time_q  <= sys_time_q + TIMER_W'(1);
      irq_prev_q  <= irq_i;
      mask_q      <= mask_nxt;
      srr_q       <= srr_nxt;
      isr_q       <= pick_any ? (NUM_TASKS'(1) << pick_idx) : '0;
      run_idx_o   <= pick_any ? pick_idx : '0;
      run_valid_o <= pick_any;
    end
  end

  // R1
  prio_top_chk: assert property (@(posedge clk) disable iff (rst)
    run_valid_o |-> ((srr_q & ~mask_q & above_mask(run_idx_o)) == '0));

  // R4
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    run_valid_o |-> (srr_q[run_idx_o] && !mask_q[run_idx_o]));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run_valid_o |-> (run_idx_o == '0 && (srr_q & ~mask_q) == '0));

  // R1
  isr_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr_q));
endmodule

// File: tb/sim_hw_task_sched.sv
module sim_hw_task_sched;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] irq_i = '0;
  logic        sw_act_i = 1'b0;
  logic [3:0]  sw_act_idx_i = '0;
  logic        done_i = 1'b0;
  logic        beat_i = 1'b0;
  logic [3:0]  run_idx_o;
  logic        run_valid_o;
  logic [15:0] wdt_err_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hw_task_sched u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .irq_i(irq_i), .sw_act_i(sw_act_i),
    .sw_act_idx_i(sw_act_idx_i), .done_i(done_i), .beat_i(beat_i),
    .run_idx_o(run_idx_o), .run_valid_o(run_valid_o), .wdt_err_o(wdt_err_o)
  );

  // {mask, irq burst, expected valid, expected index}
  localparam logic [36:0] VEC [10] = '{
    {16'h0000, 16'h0001, 1'b1, 4'd0},
    {16'h0000, 16'h8080, 1'b1, 4'd7},
    {16'h0000, 16'h0000, 1'b0, 4'd0},
    {16'h0001, 16'h0003, 1'b1, 4'd1},
    {16'hFFFF, 16'h00FF, 1'b0, 4'd0},
    {16'h0000, 16'h0F00, 1'b0, 4'd0},
    {16'h0000, 16'h8F00, 1'b1, 4'd15},
    {16'h00FE, 16'h1004, 1'b1, 4'd12},
    {16'h0000, 16'h4020, 1'b1, 4'd5},
    {16'h7FFF, 16'hC000, 1'b1, 4'd15}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic write_reg(input logic [4:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1;
    do_reset();
    // R11 R7 R10 reset state
    check("R11 valid", run_valid_o, 0);
    check("R7 idle idx", run_idx_o, 0);
    check("R10 err", wdt_err_o, 0);

    // R1 R4 R3 priority table
    for (int v = 0; v < 10; v++) begin
      do_reset();
      write_reg(5'd16, VEC[v][36:21]);
      irq_i = VEC[v][20:5];
      tick();
      irq_i = '0;
      check("R1 vec valid", run_valid_o, VEC[v][4]);
      check("R1 vec idx", run_idx_o, VEC[v][3:0]);
    end

    // R5 R6 R2 preemption and release
    do_reset();
    irq_i = 16'h8000; tick();
    check("R2 edge start", run_idx_o, 15);
    irq_i = 16'h8008; tick();
    check("R5 preempt", run_idx_o, 3);
    done_i = 1'b1; tick(); done_i = 1'b0;
    check("R6 release", run_idx_o, 15);
    check("R6 release valid", run_valid_o, 1);
    done_i = 1'b1; tick(); done_i = 1'b0;
    check("R2 held line", run_valid_o, 0);
    tick();
    check("R2 held line later", run_valid_o, 0);
    irq_i = '0;

    // R4 masked request kept pending
    do_reset();
    write_reg(5'd16, 16'h0010);
    irq_i = 16'h0010; tick(); irq_i = '0;
    check("R4 masked", run_valid_o, 0);
    write_reg(5'd16, 16'h0000);
    check("R4 unmask valid", run_valid_o, 1);
    check("R4 unmask idx", run_idx_o, 4);

    // R3 software activation
    do_reset();
    sw_act_i = 1'b1; sw_act_idx_i = 4'd6; tick();
    check("R3 sw act", run_idx_o, 6);
    sw_act_idx_i = 4'd9; done_i = 1'b1; tick();
    sw_act_i = 1'b0; done_i = 1'b0;
    check("R3 timer slot ignores sw", run_valid_o, 0);

    // R8 R9 R10 periodic slot and watchdog
    do_reset();
    write_reg(5'd9, 16'd5);
    for (int k = 1; k <= 4; k++) begin
      tick();
      check("R8 before match", run_valid_o, 0);
    end
    tick();
    check("R8 first match idx", run_idx_o, 9);
    check("R8 first match valid", run_valid_o, 1);
    beat_i = 1'b1; tick(); beat_i = 1'b0;
    done_i = 1'b1; tick(); done_i = 1'b0;
    check("R6 timer done", run_valid_o, 0);
    tick(); tick(); tick();
    check("R8 second match", run_valid_o, 1);
    check("R9 good window", wdt_err_o, 0);
    done_i = 1'b1; tick(); done_i = 1'b0;
    tick(); tick(); tick(); tick();
    check("R8 third match", run_idx_o, 9);
    check("R9 missed report", wdt_err_o, 16'h0200);
    tick();
    check("R10 sticky", wdt_err_o, 16'h0200);
    write_reg(5'd9, 16'd0);
    check("R10 clear on write", wdt_err_o, 0);
    done_i = 1'b1; tick(); done_i = 1'b0;
    repeat (10) tick();
    check("R8 period zero", run_valid_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule